// File: doc/BRIEF.md
# Prioritized Exception Masking Arbiter

This block decides which pending exception, if any, is allowed to interrupt the code that is running now. It takes one pending bit per exception number. Number 0 means "no exception". Numbers 1 to 15 are system exceptions, and numbers 16 and up are external interrupt lines. The block keeps an 8-bit programmable priority for every exception except the first three. Those three are reset (1), the non-maskable interrupt (2) and hard fault (3), and their priorities are fixed above every programmable level. A numerically smaller priority wins. Among candidates of equal priority, the smallest exception number wins.

On top of this arbitration sit three mask registers:

- a one-bit global mask, which lets only the non-maskable interrupt and hard fault through;
- a one-bit fault mask, which lets only the non-maskable interrupt through;
- an 8-bit threshold, which blocks programmable exceptions at or below a given urgency.

The block also holds the active exception number. It reads 0 in thread mode and holds the running handler's number otherwise. A candidate is offered to the core only if it is strictly more urgent than the active handler, which gives nested handling. The core pulses `enter_i` when it accepts the offered exception. It pulses `exit_i` with the number to restore when a handler returns.

Top module: `exc_arbiter`

## Requirements
- R1: After a synchronous reset, `take_o`, `win_num_o` and `act_num_o` are 0, all three masks are clear and all programmable priorities are 0.
- R2: A priority write with `prio_we_i` takes effect only for numbers 4 and above. Writes to numbers 0 to 3 are ignored. Reset, NMI and hard fault rank in that order, ahead of every programmable priority, including 0.
- R3: The eligible pending exception with the numerically smallest effective priority wins. On a tie, the smallest exception number wins.
- R4: `msk_we_i` with `msk_sel_i`=0 loads bit 0 of `msk_val_i` into the global mask. While it is set, only numbers 2 and 3 can be offered.
- R5: `msk_sel_i`=1 loads bit 0 of `msk_val_i` into the fault mask. While it is set, only number 2 can be offered.
- R6: `msk_sel_i`=2 loads the threshold. A nonzero threshold T blocks every programmable exception whose priority is greater than or equal to T. A threshold of 0 blocks nothing, and numbers 1 to 3 are never affected by the threshold.
- R7: An eligible winner is offered only if `act_num_o` is 0 or the winner's priority is strictly more urgent than that of the active number. Equal priority does not preempt.
- R8: `take_o` and `win_num_o` are registered and reflect inputs from the previous clock edge. `win_num_o` is 0 whenever `take_o` is 0. Pending bit 0 is ignored.
- R9: `enter_i` loads `act_num_o` with the current `win_num_o` on the next edge. Otherwise `exit_i` loads it with `ret_num_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NUM_EXC | Pending bit per exception number |
| prio_we_i | input | 1 | Priority write strobe |
| prio_num_i | input | NW | Exception number to program |
| prio_val_i | input | PRIO_W | Priority value to write |
| msk_we_i | input | 1 | Mask write strobe |
| msk_sel_i | input | 2 | 0 global, 1 fault, 2 threshold |
| msk_val_i | input | PRIO_W | Mask value (bit 0 for one-bit masks) |
| enter_i | input | 1 | Core accepts offered exception |
| exit_i | input | 1 | Handler return |
| ret_num_i | input | NW | Number to restore on return |
| take_o | output | 1 | Preemption request |
| win_num_o | output | NW | Offered exception number |
| act_num_o | output | NW | Active exception number |

## Verification
A corrupted mask register appears one edge later as a wrong `take_o` value. An excluded number is offered, or a legitimate one is withheld, on the very first cycle the affected exception is pending. A wrong stored priority or tree compare appears as the wrong `win_num_o` when two candidates are pending together, so the bench pairs candidates at each ordering boundary. A stale or wrong active number appears as a missed or spurious preemption two edges after the handler changes.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int unsigned FIXED_CNT = 3;
  localparam int unsigned RESET_NUM = 1;
  localparam int unsigned NMI_NUM   = 2;
  localparam int unsigned HF_NUM    = 3;

  typedef enum logic [1:0] {
    MSK_GLOBAL = 2'd0,
    MSK_FAULT  = 2'd1,
    MSK_THRESH = 2'd2
  } msk_sel_e;
endpackage

// File: rtl/exc_prio_table.sv
module exc_prio_table
  import exc_arb_pkg::*;
#(
  parameter int unsigned NUM_EXC = 256,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned NW = $clog2(NUM_EXC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we_i,
  input  logic [NW-1:0]             num_i,
  input  logic [PRIO_W-1:0]         val_i,
  output logic [NUM_EXC*PRIO_W-1:0] prio_flat_o
);
  // All entries are read in parallel by the arbiter, so this is a flop array.
  logic [PRIO_W-1:0] mem_q [NUM_EXC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NUM_EXC); i++) mem_q[i] <= '0;
    end else if (we_i && (int'(num_i) > int'(FIXED_CNT))) begin
      mem_q[num_i] <= val_i;
    end
  end

  for (genvar g = 0; g < int'(NUM_EXC); g++) begin : g_out
    assign prio_flat_o[g*PRIO_W +: PRIO_W] = mem_q[g];
  end
endmodule

// File: rtl/exc_mask_ctrl.sv
module exc_mask_ctrl
  import exc_arb_pkg::*;
#(
  parameter int unsigned NUM_EXC = 256,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned KW = PRIO_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we_i,
  input  logic [1:0]                sel_i,
  input  logic [PRIO_W-1:0]         val_i,
  input  logic [NUM_EXC-1:0]        pend_i,
  input  logic [NUM_EXC*PRIO_W-1:0] prio_flat_i,
  output logic                      gm_o,
  output logic                      fm_o,
  output logic [PRIO_W-1:0]         thr_o,
  output logic [NUM_EXC-1:0]        elig_o,
  output logic [NUM_EXC*KW-1:0]     key_flat_o
);
  logic              gm_q, fm_q;
  logic [PRIO_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gm_q  <= 1'b0;
      fm_q  <= 1'b0;
      thr_q <= '0;
    end else if (we_i) begin
      unique case (msk_sel_e'(sel_i))
        MSK_GLOBAL: gm_q  <= val_i[0];
        MSK_FAULT:  fm_q  <= val_i[0];
        MSK_THRESH: thr_q <= val_i;
        default: ;
      endcase
    end
  end

  assign gm_o  = gm_q;
  assign fm_o  = fm_q;
  assign thr_o = thr_q;

  // Key: top bit 0 for fixed system exceptions, 1 for programmable ones.
  for (genvar n = 0; n < int'(NUM_EXC); n++) begin : g_ex
    if (n == 0) begin : g_none
      assign elig_o[n] = 1'b0;
      assign key_flat_o[n*KW +: KW] = '1;
    end else if (n <= int'(FIXED_CNT)) begin : g_fix
      localparam logic [KW-2:0] FIXK = (KW-1)'(n - 1);
      assign key_flat_o[n*KW +: KW] = {1'b0, FIXK};
      if (n == int'(NMI_NUM)) begin : g_nmi
        assign elig_o[n] = pend_i[n];
      end else if (n == int'(HF_NUM)) begin : g_hf
        assign elig_o[n] = pend_i[n] && !fm_q;
      end else begin : g_rst
        assign elig_o[n] = pend_i[n] && !fm_q && !gm_q;
      end
    end else begin : g_prog
      logic [PRIO_W-1:0] p;
      assign p = prio_flat_i[n*PRIO_W +: PRIO_W];
      assign key_flat_o[n*KW +: KW] = {1'b1, p};
      assign elig_o[n] = pend_i[n] && !gm_q && !fm_q &&
                         !((thr_q != '0) && (p >= thr_q));
    end
  end
endmodule

// File: rtl/exc_min_tree.sv
module exc_min_tree #(
  parameter int unsigned LEAVES = 256,
  parameter int unsigned KW     = 9,
  localparam int unsigned IW    = $clog2(LEAVES),
  localparam int unsigned NODES = 2*LEAVES - 1
) (
  input  logic [LEAVES-1:0]    vld_i,
  input  logic [LEAVES*KW-1:0] key_i,
  output logic                 vld_o,
  output logic [KW-1:0]        key_o,
  output logic [IW-1:0]        idx_o
);
  logic          nv [NODES];
  logic [KW-1:0] nk [NODES];
  logic [IW-1:0] ni [NODES];

  for (genvar j = 0; j < int'(LEAVES); j++) begin : g_leaf
    assign nv[LEAVES-1+j] = vld_i[j];
    assign nk[LEAVES-1+j] = key_i[j*KW +: KW];
    assign ni[LEAVES-1+j] = IW'(j);
  end

  // Left subtree holds lower numbers, so it wins ties.
  for (genvar i = 0; i < int'(LEAVES) - 1; i++) begin : g_node
    logic pick_l;
    assign pick_l = nv[2*i+1] && (!nv[2*i+2] || (nk[2*i+1] <= nk[2*i+2]));
    assign nv[i] = nv[2*i+1] || nv[2*i+2];
    assign nk[i] = pick_l ? nk[2*i+1] : nk[2*i+2];
    assign ni[i] = pick_l ? ni[2*i+1] : ni[2*i+2];
  end

  assign vld_o = nv[0];
  assign key_o = nk[0];
  assign idx_o = ni[0];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int unsigned NUM_EXC = 256,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned NW     = $clog2(NUM_EXC),
  localparam int unsigned KW     = PRIO_W + 1,
  localparam int unsigned LEAVES = 1 << NW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] pend_i,
  input  logic               prio_we_i,
  input  logic [NW-1:0]      prio_num_i,
  input  logic [PRIO_W-1:0]  prio_val_i,
  input  logic               msk_we_i,
  input  logic [1:0]         msk_sel_i,
  input  logic [PRIO_W-1:0]  msk_val_i,
  input  logic               enter_i,
  input  logic               exit_i,
  input  logic [NW-1:0]      ret_num_i,
  output logic               take_o,
  output logic [NW-1:0]      win_num_o,
  output logic [NW-1:0]      act_num_o
);
  logic [NUM_EXC*PRIO_W-1:0] prio_flat;
  logic [NUM_EXC*KW-1:0]     key_flat;
  logic [NUM_EXC-1:0]        elig;
  logic                      gm_w, fm_w;
  logic [PRIO_W-1:0]         thr_w;
  logic [LEAVES-1:0]         leaf_v;
  logic [LEAVES*KW-1:0]      leaf_k;
  logic                      win_v;
  logic [KW-1:0]             win_k, act_k;
  logic [NW-1:0]             win_i;
  logic                      take_d;
  logic                      take_q;
  logic [NW-1:0]             win_q, act_q;

  exc_prio_table #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_prio (
    .clk(clk), .rst(rst), .we_i(prio_we_i), .num_i(prio_num_i),
    .val_i(prio_val_i), .prio_flat_o(prio_flat)
  );

  exc_mask_ctrl #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_mask (
    .clk(clk), .rst(rst), .we_i(msk_we_i), .sel_i(msk_sel_i),
    .val_i(msk_val_i), .pend_i(pend_i), .prio_flat_i(prio_flat),
    .gm_o(gm_w), .fm_o(fm_w), .thr_o(thr_w),
    .elig_o(elig), .key_flat_o(key_flat)
  );

  if (LEAVES > NUM_EXC) begin : g_pad
    assign leaf_v = {{(LEAVES-NUM_EXC){1'b0}}, elig};
    assign leaf_k = {{((LEAVES-NUM_EXC)*KW){1'b1}}, key_flat};
  end else begin : g_nopad
    assign leaf_v = elig;
    assign leaf_k = key_flat;
  end

  exc_min_tree #(.LEAVES(LEAVES), .KW(KW)) u_tree (
    .vld_i(leaf_v), .key_i(leaf_k),
    .vld_o(win_v), .key_o(win_k), .idx_o(win_i)
  );

  // Active priority is looked up from the active number, not stored.
  assign act_k  = key_flat[act_q*KW +: KW];
  assign take_d = win_v && ((act_q == '0) || (win_k < act_k));

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      win_q  <= '0;
      act_q  <= '0;
    end else begin
      take_q <= take_d;
      win_q  <= take_d ? win_i : '0;
      if (enter_i)     act_q <= win_q;
      else if (exit_i) act_q <= ret_num_i;
    end
  end

  assign take_o    = take_q;
  assign win_num_o = win_q;
  assign act_num_o = act_q;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk #(
  parameter int unsigned NUM_EXC = 256,
  parameter int unsigned NW      = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EXC-1:0] pend_i,
  input logic               enter_i,
  input logic               exit_i,
  input logic [NW-1:0]      ret_num_i,
  input logic               take_o,
  input logic [NW-1:0]      win_num_o,
  input logic [NW-1:0]      act_num_o,
  input logic               gm,
  input logic               fm
);
  logic [NUM_EXC-1:0] pend_d;
  logic               gm_d, fm_d;

  always_ff @(posedge clk) begin
    pend_d <= pend_i;
    gm_d   <= gm;
    fm_d   <= fm;
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !take_o |-> (win_num_o == '0));

  assert_win_pending_R8: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (pend_d[win_num_o] && (win_num_o != '0)));

  assert_global_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (take_o && gm_d) |-> ((win_num_o == NW'(2)) || (win_num_o == NW'(3))));

  assert_fault_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (take_o && fm_d) |-> (win_num_o == NW'(2)));

  assert_enter_load_R9: assert property (@(posedge clk) disable iff (rst)
    enter_i |=> (act_num_o == $past(win_num_o)));

  assert_exit_load_R9: assert property (@(posedge clk) disable iff (rst)
    (exit_i && !enter_i) |=> (act_num_o == $past(ret_num_i)));
endmodule

bind exc_arbiter exc_arbiter_chk #(.NUM_EXC(NUM_EXC), .NW(NW)) u_chk (
  .clk(clk), .rst(rst), .pend_i(pend_i), .enter_i(enter_i),
  .exit_i(exit_i), .ret_num_i(ret_num_i), .take_o(take_o),
  .win_num_o(win_num_o), .act_num_o(act_num_o), .gm(gm_w), .fm(fm_w)
);

// File: tb/exc_arbiter_bench.sv
module exc_arbiter_bench;
  localparam int NUM_EXC = 256;
  localparam int PRIO_W  = 8;
  localparam int NW      = 8;
  localparam int NVEC    = 19;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_EXC-1:0] pend = '0;
  logic               prio_we = 1'b0;
  logic [NW-1:0]      prio_num = '0;
  logic [PRIO_W-1:0]  prio_val = '0;
  logic               msk_we = 1'b0;
  logic [1:0]         msk_sel = '0;
  logic [PRIO_W-1:0]  msk_val = '0;
  logic               enter = 1'b0;
  logic               exit_r = 1'b0;
  logic [NW-1:0]      ret_num = '0;
  logic               take;
  logic [NW-1:0]      win_num, act_num;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  exc_arbiter u_exc_arbiter (
    .clk(clk), .rst(rst), .pend_i(pend), .prio_we_i(prio_we),
    .prio_num_i(prio_num), .prio_val_i(prio_val), .msk_we_i(msk_we),
    .msk_sel_i(msk_sel), .msk_val_i(msk_val), .enter_i(enter),
    .exit_i(exit_r), .ret_num_i(ret_num), .take_o(take),
    .win_num_o(win_num), .act_num_o(act_num)
  );

  // Fields: pendA[42:35] pendB[34:27] gm[26] fm[25] thr[24:17] act[16:9] take[8] num[7:0]
  localparam logic [42:0] VEC [NVEC] = '{
    {8'd16,  8'd17,  1'b0, 1'b0, 8'h00, 8'd0,  1'b1, 8'd16 },  // R3 tie
    {8'd16,  8'd20,  1'b0, 1'b0, 8'h00, 8'd0,  1'b1, 8'd20 },  // R3
    {8'd5,   8'd200, 1'b0, 1'b0, 8'h00, 8'd0,  1'b1, 8'd200},  // R3
    {8'd2,   8'd200, 1'b0, 1'b0, 8'h00, 8'd0,  1'b1, 8'd2  },  // R2
    {8'd1,   8'd2,   1'b0, 1'b0, 8'h00, 8'd0,  1'b1, 8'd1  },  // R2
    {8'd3,   8'd20,  1'b1, 1'b0, 8'h00, 8'd0,  1'b1, 8'd3  },  // R4
    {8'd20,  8'd0,   1'b1, 1'b0, 8'h00, 8'd0,  1'b0, 8'd0  },  // R4
    {8'd3,   8'd2,   1'b0, 1'b1, 8'h00, 8'd0,  1'b1, 8'd2  },  // R5
    {8'd3,   8'd20,  1'b0, 1'b1, 8'h00, 8'd0,  1'b0, 8'd0  },  // R5
    {8'd20,  8'd200, 1'b0, 1'b0, 8'h20, 8'd0,  1'b1, 8'd20 },  // R6 equal blocked
    {8'd200, 8'd0,   1'b0, 1'b0, 8'h20, 8'd0,  1'b0, 8'd0  },  // R6
    {8'd200, 8'd0,   1'b0, 1'b0, 8'h00, 8'd0,  1'b1, 8'd200},  // R6 zero
    {8'd16,  8'd0,   1'b0, 1'b0, 8'h00, 8'd20, 1'b0, 8'd0  },  // R7
    {8'd20,  8'd0,   1'b0, 1'b0, 8'h00, 8'd20, 1'b0, 8'd0  },  // R7 equal
    {8'd200, 8'd0,   1'b0, 1'b0, 8'h00, 8'd16, 1'b1, 8'd200},  // R7
    {8'd3,   8'd0,   1'b0, 1'b0, 8'h00, 8'd2,  1'b0, 8'd0  },  // R7 fixed
    {8'd255, 8'd0,   1'b0, 1'b0, 8'h00, 8'd5,  1'b0, 8'd0  },  // R7
    {8'd0,   8'd0,   1'b0, 1'b0, 8'h00, 8'd0,  1'b0, 8'd0  },  // R8 bit0
    {8'd3,   8'd200, 1'b0, 1'b0, 8'h01, 8'd0,  1'b1, 8'd3  }   // R2 R6 fixed
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_prio(input int n, input int v);
    prio_we = 1'b1; prio_num = NW'(n); prio_val = PRIO_W'(v);
    tick(1);
    prio_we = 1'b0;
  endtask

  task automatic wr_mask(input int s, input int v);
    msk_we = 1'b1; msk_sel = 2'(s); msk_val = PRIO_W'(v);
    tick(1);
    msk_we = 1'b0;
  endtask

  task automatic set_act(input int n);
    exit_r = 1'b1; ret_num = NW'(n);
    tick(1);
    exit_r = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 take", 32'(take), 0);
    chk("R1 win", 32'(win_num), 0);
    chk("R1 act", 32'(act_num), 0);
    rst = 1'b0;
    pend[16] = 1'b1; pend[17] = 1'b1;
    tick(2);
    chk("R1 prio reset tie", 32'(win_num), 16);
    pend = '0;

    wr_prio(16, 'h40); wr_prio(17, 'h40); wr_prio(20, 'h10);
    wr_prio(5, 'h80);  wr_prio(200, 'h20); wr_prio(255, 'hFF);
    wr_prio(3, 'hFF);  wr_prio(1, 'hFF);

    for (int i = 0; i < NVEC; i++) begin
      logic [42:0] v;
      v = VEC[i];
      pend = '0;
      wr_mask(0, int'(v[26]));
      wr_mask(1, int'(v[25]));
      wr_mask(2, int'(v[24:17]));
      set_act(int'(v[16:9]));
      if (v[42:35] != 0) pend[v[42:35]] = 1'b1; else pend[0] = 1'b1;
      if (v[34:27] != 0) pend[v[34:27]] = 1'b1;
      tick(2);
      chk($sformatf("R3-vector %0d take R8", i), 32'(take), 32'(v[8]));
      chk($sformatf("R3-vector %0d num R2", i), 32'(win_num), 32'(v[7:0]));
    end

    // Directed: R9 enter and exit.
    pend = '0;
    wr_mask(0, 0); wr_mask(1, 0); wr_mask(2, 0);
    set_act(0);
    pend[20] = 1'b1;
    tick(2);
    chk("R9 offer", 32'(win_num), 20);
    enter = 1'b1;
    tick(1);
    enter = 1'b0;
    chk("R9 enter act", 32'(act_num), 20);
    tick(1);
    chk("R7 no self preempt", 32'(take), 0);
    pend[2] = 1'b1;
    tick(2);
    chk("R7 NMI nests", 32'(win_num), 2);
    pend[2] = 1'b0;
    set_act(0);
    chk("R9 exit act", 32'(act_num), 0);
    tick(1);
    chk("R9 thread retake", 32'(take), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule